// File: doc/BRIEF.md
# Wide Register Access Collector Bridge

This block connects a 32-bit host register port to internal registers that are 128 bits wide and to a small SRAM that holds 64-bit words. The host can only move one dword per access. The bridge therefore hides how wide the storage is.

On the read side, the first dword of a wide register captures the whole register into a snapshot latch. The higher dwords of that register are then served from the snapshot. On the write side, partial writes gather in a collector. The target is updated only once every dword of it has arrived.

Two write-only descriptor-pointer registers are handled differently. They are updated whenever their top dword is written. Any low dwords the collector did not supply are filled with zero. A low-dword write to one of them is dropped when the collector is busy with another register. These pointers, together with an event-queue pointer and a timer command, repeat in every page of a paged address window. Each write to them is presented to the consumer on a one-cycle strobe that carries the page number.

Top module: `wide_csr_bridge`

## Requirements
- R1: After reset every strobe output is low, `hst_rvalid` is low and every wide register and SRAM word reads as zero.
- R2: A read of dword 0 of a wide register (page 0, offsets 0x000 + 16·n) or of dword 0 of an SRAM word (0x1000 + 8·n) latches the full current value. A later read of a higher dword of the same target returns the latched value, even if the target has been rewritten in between.
- R3: A read of any dword of a target other than the one held in the latch, or with the latch empty, refetches the live value into the latch and returns the addressed dword of it.
- R4: Writes to a wide register collect in any order. The register changes only in the cycle that supplies the last missing of its four dwords, and it then takes all four collected dwords.
- R5: A write to a wide register or SRAM word other than the collector's current target restarts collection with that dword alone. The earlier partial data is lost.
- R6: SRAM words follow R2 to R5 with two dwords (offset bit 2 picks the dword), and commit once both are collected.
- R7: A write to the top dword (offset +0xC) of a descriptor pointer (offset 0x830 gives `ptr_sel`=0, offset 0xA10 gives `ptr_sel`=1) always raises `ptr_we` in the next cycle. `ptr_data[127:96]` is the written dword. Each lower dword comes from the collector if it holds that dword of the same pointer in the same page, and is zero otherwise. The collector is cleared only if it held this pointer.
- R8: A write to a lower dword of a descriptor pointer while the collector holds data for a different target is discarded, and the collector keeps its state.
- R9: Paged registers live at page·0x2000 + offset, with the page in address bits 15:13. Writes to pages at or above NUM_PAGES (default 4) have no effect. Wide registers and SRAM exist only in page 0.
- R10: A write to the event-queue pointer (offset 0x400, `dw_sel`=0) or the timer command (offset 0x420, `dw_sel`=1) raises `dw_we` in the next cycle with the written data and the page.
- R11: A timer-command write in page 0 empties the collector. A timer-command write in any other page does not.
- R12: Reads of descriptor pointers, paged dword registers and unmapped addresses return zero. No read alters the collector.
- R13: `hst_rvalid` and `hst_rdata` answer a read in the following cycle. When `hst_rd` and `hst_wr` are both high, only the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hst_rd | input | 1 | Host read request, one cycle |
| hst_wr | input | 1 | Host write request, one cycle |
| hst_addr | input | 16 | Host byte address; bits 1:0 ignored |
| hst_wdata | input | 32 | Host write dword |
| hst_rdata | output | 32 | Read dword, valid with `hst_rvalid` |
| hst_rvalid | output | 1 | Read answer strobe |
| ptr_we | output | 1 | Descriptor pointer update strobe |
| ptr_sel | output | 1 | 0 for the pointer at 0x830, 1 for the pointer at 0xA10 |
| ptr_page | output | 3 | Page of the pointer update |
| ptr_data | output | 128 | New 128-bit pointer value |
| dw_we | output | 1 | Paged dword register write strobe |
| dw_sel | output | 1 | 0 for the event-queue pointer, 1 for the timer command |
| dw_page | output | 3 | Page of the dword write |
| dw_data | output | 32 | Written dword |

## Verification
Wide registers are written with all four dwords in shuffled order, and read back both before and after the last dword arrives. This separates "commit when complete" from "commit on the last address". Reads are ordered so that a snapshot goes stale between its first and its later dwords, and so that a read jumps between registers. This tells latched data apart from live data.

Descriptor-pointer updates are run in three situations: after low dwords of the same pointer, with no low dwords at all, and while an ordinary register is half collected. Together these expose the zero fill, the conflict drop, and whether a foreign collection survives. Timer writes in page 0 and in another page, paged writes past the last page, and combined read/write requests cover invalidation, page decoding and request priority.

// File: rtl/wcb_pkg.sv
package wcb_pkg;
  localparam int ADDR_W   = 16;
  localparam int OFS_W    = 13;
  localparam int PAGE_W   = ADDR_W - OFS_W;
  localparam int IDX_W    = 4;
  localparam int WORD_W   = 128;
  localparam int SWORD_W  = 64;
  localparam int DW_PER_W = WORD_W / 32;

  localparam logic [OFS_W-5:0] PTR0_ROW = 9'h083;
  localparam logic [OFS_W-5:0] PTR1_ROW = 9'h0A1;
  localparam logic [OFS_W-5:0] EVQ_ROW  = 9'h040;
  localparam logic [OFS_W-5:0] TMR_ROW  = 9'h042;

  typedef enum logic [2:0] {
    K_NONE, K_WIDE, K_SRAM, K_PTR, K_EVQ, K_TMR
  } kind_e;

  typedef struct packed {
    kind_e               kind;
    logic [ADDR_W-1:0]   base;
    logic [1:0]          dw;
    logic [IDX_W-1:0]    idx;
    logic [PAGE_W-1:0]   page;
    logic                sel;
  } dec_t;
endpackage

// File: rtl/wcb_decode.sv
module wcb_decode
  import wcb_pkg::*;
#(
  parameter int NUM_WIDE  = 8,
  parameter int NUM_SRAM  = 16,
  parameter int NUM_PAGES = 4,
  parameter logic [OFS_W-1:0] SRAM_OFS = 13'h1000
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam logic [OFS_W-1:0] WIDE_END  = OFS_W'(NUM_WIDE * 16);
  localparam logic [OFS_W-1:0] SRAM_SPAN = OFS_W'(NUM_SRAM * 8);

  logic [PAGE_W-1:0] page;
  logic [OFS_W-1:0]  ofs;
  logic [OFS_W-1:0]  sofs;

  always_comb begin
    page     = addr[ADDR_W-1 -: PAGE_W];
    ofs      = addr[OFS_W-1:0];
    sofs     = ofs - SRAM_OFS;
    dec      = '0;
    dec.kind = K_NONE;
    dec.page = page;
    dec.dw   = ofs[3:2];
    dec.base = {addr[ADDR_W-1:4], 4'h0};
    if (page == '0 && ofs < WIDE_END) begin
      dec.kind = K_WIDE;
      dec.idx  = ofs[4 +: IDX_W];
    end else if (page == '0 && ofs >= SRAM_OFS && sofs < SRAM_SPAN) begin
      dec.kind = K_SRAM;
      dec.idx  = sofs[3 +: IDX_W];
      dec.dw   = {1'b0, ofs[2]};
      dec.base = {addr[ADDR_W-1:3], 3'h0};
    end else if (32'(page) < 32'(NUM_PAGES)) begin
      case (ofs[OFS_W-1:4])
        PTR0_ROW: begin dec.kind = K_PTR; dec.sel = 1'b0; end
        PTR1_ROW: begin dec.kind = K_PTR; dec.sel = 1'b1; end
        EVQ_ROW:  if (ofs[3:2] == 2'd0) dec.kind = K_EVQ;
        TMR_ROW:  if (ofs[3:2] == 2'd0) begin dec.kind = K_TMR; dec.sel = 1'b1; end
        default:  dec.kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/wcb_store.sv
module wcb_store
  import wcb_pkg::*;
#(
  parameter int NUM_WIDE = 8,
  parameter int NUM_SRAM = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_we,
  input  logic [IDX_W-1:0]    wide_widx,
  input  logic [WORD_W-1:0]   wide_wdata,
  input  logic                sram_we,
  input  logic [IDX_W-1:0]    sram_widx,
  input  logic [SWORD_W-1:0]  sram_wdata,
  input  logic [IDX_W-1:0]    ridx,
  output logic [WORD_W-1:0]   wide_rdata,
  output logic [SWORD_W-1:0]  sram_rdata
);
  localparam int WI_W = (NUM_WIDE > 1) ? $clog2(NUM_WIDE) : 1;
  localparam int SI_W = (NUM_SRAM > 1) ? $clog2(NUM_SRAM) : 1;

  logic [WORD_W-1:0]  wide_q [NUM_WIDE];
  logic [SWORD_W-1:0] sram_q [NUM_SRAM];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WIDE; i++) wide_q[i] <= '0;
    end else if (wide_we) begin
      wide_q[wide_widx[WI_W-1:0]] <= wide_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRAM; i++) sram_q[i] <= '0;
    end else if (sram_we) begin
      sram_q[sram_widx[SI_W-1:0]] <= sram_wdata;
    end
  end

  assign wide_rdata = wide_q[ridx[WI_W-1:0]];
  assign sram_rdata = sram_q[ridx[SI_W-1:0]];
endmodule

// File: rtl/wcb_collector.sv
module wcb_collector
  import wcb_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  dec_t                dec,
  input  logic [31:0]         wdata,
  output logic                wide_we,
  output logic                sram_we,
  output logic [WORD_W-1:0]   commit_data,
  output logic                ptr_fire,
  output logic [WORD_W-1:0]   ptr_value
);
  logic [ADDR_W-1:0]   col_tag,  n_tag;
  logic [DW_PER_W-1:0] col_mask, n_mask;
  logic [WORD_W-1:0]   col_data, n_data;
  logic                col_en;

  logic                hit;
  logic [DW_PER_W-1:0] base_mask, merged_mask, full_mask;
  logic [WORD_W-1:0]   base_data, merged_data, fill;

  assign hit       = (col_mask != '0) && (col_tag == dec.base);
  assign base_mask = hit ? col_mask : '0;
  assign base_data = hit ? col_data : '0;
  assign full_mask = (dec.kind == K_SRAM) ? 4'h3 : 4'hF;

  for (genvar g = 0; g < DW_PER_W; g++) begin : g_fill
    assign fill[g*32 +: 32] = base_mask[g] ? base_data[g*32 +: 32] : 32'h0;
  end

  always_comb begin
    merged_mask = base_mask | (4'b0001 << dec.dw);
    merged_data = fill;
    merged_data[dec.dw*32 +: 32] = wdata;
  end

  always_comb begin
    n_tag       = col_tag;
    n_mask      = col_mask;
    n_data      = col_data;
    wide_we     = 1'b0;
    sram_we     = 1'b0;
    ptr_fire    = 1'b0;
    commit_data = merged_data;
    ptr_value   = {wdata, fill[95:0]};
    if (wr) begin
      unique case (dec.kind)
        K_WIDE, K_SRAM: begin
          if (merged_mask == full_mask) begin
            wide_we = (dec.kind == K_WIDE);
            sram_we = (dec.kind == K_SRAM);
            n_tag = '0; n_mask = '0; n_data = '0;
          end else begin
            n_tag = dec.base; n_mask = merged_mask; n_data = merged_data;
          end
        end
        K_PTR: begin
          if (dec.dw == 2'd3) begin
            ptr_fire = 1'b1;
            if (hit) begin n_tag = '0; n_mask = '0; n_data = '0; end
          end else if (col_mask == '0 || hit) begin
            n_tag = dec.base; n_mask = merged_mask; n_data = merged_data;
          end
        end
        K_TMR: begin
          if (dec.page == '0) begin n_tag = '0; n_mask = '0; n_data = '0; end
        end
        default: ;
      endcase
    end
  end

  assign col_en = wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_tag  <= '0;
      col_mask <= '0;
      col_data <= '0;
    end else if (col_en) begin
      col_tag  <= n_tag;
      col_mask <= n_mask;
      col_data <= n_data;
    end
  end

  a_r11_timer_page0_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.kind == K_TMR && dec.page == '0) |=> (col_mask == '0));

  a_r8_conflict_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && dec.kind == K_PTR && dec.dw != 2'd3 && col_mask != '0 && col_tag != dec.base)
    |=> ($stable(col_mask) && $stable(col_tag) && $stable(col_data)));

  a_r12_idle_keeps_collector: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> ($stable(col_mask) && $stable(col_tag)));
endmodule

// File: rtl/wcb_read_latch.sv
module wcb_read_latch
  import wcb_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd,
  input  dec_t               dec,
  input  logic [WORD_W-1:0]  live,
  output logic [31:0]        rdata,
  output logic               rvalid
);
  logic                lat_v,    n_lat_v;
  logic [ADDR_W-1:0]   lat_tag,  n_lat_tag;
  logic [WORD_W-1:0]   lat_data, n_lat_data;
  logic [31:0]         n_rdata;
  logic                readable, fresh;
  logic [WORD_W-1:0]   src;

  always_comb begin
    readable   = (dec.kind == K_WIDE) || (dec.kind == K_SRAM);
    fresh      = (dec.dw == 2'd0) || !lat_v || (lat_tag != dec.base);
    src        = fresh ? live : lat_data;
    n_rdata    = readable ? src[dec.dw*32 +: 32] : 32'h0;
    n_lat_v    = lat_v;
    n_lat_tag  = lat_tag;
    n_lat_data = lat_data;
    if (rd && readable && fresh) begin
      n_lat_v    = 1'b1;
      n_lat_tag  = dec.base;
      n_lat_data = live;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_v    <= 1'b0;
      lat_tag  <= '0;
      lat_data <= '0;
      rdata    <= '0;
      rvalid   <= 1'b0;
    end else begin
      rvalid <= rd;
      if (rd) begin
        lat_v    <= n_lat_v;
        lat_tag  <= n_lat_tag;
        lat_data <= n_lat_data;
        rdata    <= n_rdata;
      end
    end
  end
endmodule

// File: rtl/wide_csr_bridge.sv
module wide_csr_bridge
  import wcb_pkg::*;
#(
  parameter int NUM_WIDE  = 8,
  parameter int NUM_SRAM  = 16,
  parameter int NUM_PAGES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hst_rd,
  input  logic                hst_wr,
  input  logic [ADDR_W-1:0]   hst_addr,
  input  logic [31:0]         hst_wdata,
  output logic [31:0]         hst_rdata,
  output logic                hst_rvalid,
  output logic                ptr_we,
  output logic                ptr_sel,
  output logic [PAGE_W-1:0]   ptr_page,
  output logic [WORD_W-1:0]   ptr_data,
  output logic                dw_we,
  output logic                dw_sel,
  output logic [PAGE_W-1:0]   dw_page,
  output logic [31:0]         dw_data
);
  logic rst_q1, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q1     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_q1     <= 1'b1;
      rst_sync_n <= rst_q1;
    end
  end

  dec_t               dec;
  logic               rd_eff;
  logic               wide_we, sram_we, ptr_fire;
  logic [WORD_W-1:0]  commit_data, ptr_value, wide_live;
  logic [SWORD_W-1:0] sram_live;
  logic [WORD_W-1:0]  live;

  assign rd_eff = hst_rd & ~hst_wr;

  wcb_decode #(.NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM), .NUM_PAGES(NUM_PAGES)) u_dec (
    .addr(hst_addr), .dec(dec));

  wcb_store #(.NUM_WIDE(NUM_WIDE), .NUM_SRAM(NUM_SRAM)) u_store (
    .clk(clk), .rst_n(rst_sync_n),
    .wide_we(wide_we), .wide_widx(dec.idx), .wide_wdata(commit_data),
    .sram_we(sram_we), .sram_widx(dec.idx), .sram_wdata(commit_data[SWORD_W-1:0]),
    .ridx(dec.idx), .wide_rdata(wide_live), .sram_rdata(sram_live));

  wcb_collector u_col (
    .clk(clk), .rst_n(rst_sync_n), .wr(hst_wr), .dec(dec), .wdata(hst_wdata),
    .wide_we(wide_we), .sram_we(sram_we), .commit_data(commit_data),
    .ptr_fire(ptr_fire), .ptr_value(ptr_value));

  assign live = (dec.kind == K_SRAM) ? {{(WORD_W-SWORD_W){1'b0}}, sram_live} : wide_live;

  wcb_read_latch u_rl (
    .clk(clk), .rst_n(rst_sync_n), .rd(rd_eff), .dec(dec), .live(live),
    .rdata(hst_rdata), .rvalid(hst_rvalid));

  logic              n_ptr_we, n_dw_we, out_en;
  assign n_ptr_we = ptr_fire;
  assign n_dw_we  = hst_wr && (dec.kind == K_EVQ || dec.kind == K_TMR);
  assign out_en   = n_ptr_we | n_dw_we;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_we <= 1'b0;
      dw_we  <= 1'b0;
    end else begin
      ptr_we <= n_ptr_we;
      dw_we  <= n_dw_we;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ptr_sel  <= 1'b0;
      ptr_page <= '0;
      ptr_data <= '0;
      dw_sel   <= 1'b0;
      dw_page  <= '0;
      dw_data  <= '0;
    end else if (out_en) begin
      if (n_ptr_we) begin
        ptr_sel  <= dec.sel;
        ptr_page <= dec.page;
        ptr_data <= ptr_value;
      end
      if (n_dw_we) begin
        dw_sel  <= dec.sel;
        dw_page <= dec.page;
        dw_data <= hst_wdata;
      end
    end
  end

  a_r7_top_dword_commits: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_wr && dec.kind == K_PTR && dec.dw == 2'd3) |=> (ptr_we && ptr_data[127:96] == $past(hst_wdata)));

  a_r13_read_answered: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_rd && !hst_wr) |=> hst_rvalid);

  a_r13_write_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_rd && hst_wr) |=> !hst_rvalid);

  a_r9_page_in_range: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ptr_we || dw_we) |-> (32'(ptr_we ? ptr_page : dw_page) < 32'(NUM_PAGES)));

  a_r10_dword_passes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (hst_wr && dec.kind == K_EVQ) |=> (dw_we && !dw_sel && dw_data == $past(hst_wdata)));
endmodule

// File: tb/wide_csr_bridge_tb.sv
module wide_csr_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 8;
  localparam int NS = 16;
  localparam int NP = 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         hst_rd, hst_wr;
  logic [15:0]  hst_addr;
  logic [31:0]  hst_wdata;
  logic [31:0]  hst_rdata;
  logic         hst_rvalid;
  logic         ptr_we, ptr_sel, dw_we, dw_sel;
  logic [2:0]   ptr_page, dw_page;
  logic [127:0] ptr_data;
  logic [31:0]  dw_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  wide_csr_bridge #(.NUM_WIDE(NW), .NUM_SRAM(NS), .NUM_PAGES(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .hst_rd(hst_rd), .hst_wr(hst_wr), .hst_addr(hst_addr),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rvalid(hst_rvalid),
    .ptr_we(ptr_we), .ptr_sel(ptr_sel), .ptr_page(ptr_page), .ptr_data(ptr_data),
    .dw_we(dw_we), .dw_sel(dw_sel), .dw_page(dw_page), .dw_data(dw_data));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural reference state
  logic [127:0] mw [NW];
  logic [63:0]  ms [NS];
  int           ctag;
  logic [3:0]   cmask;
  logic [127:0] cdata;
  bit           lv;
  int           ltag;
  logic [127:0] ldata;

  bit           e_rvalid, e_ptr_we, e_ptr_sel, e_dw_we, e_dw_sel;
  logic [31:0]  e_rdata, e_dw_data;
  logic [2:0]   e_ptr_page, e_dw_page;
  logic [127:0] e_ptr_data;
  string        cur_req = "R1";

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(hst_rvalid == e_rvalid, cur_req, "rvalid", 128'(hst_rvalid), 128'(e_rvalid));
    if (e_rvalid) chk(hst_rdata == e_rdata, cur_req, "rdata", 128'(hst_rdata), 128'(e_rdata));
    chk(ptr_we == e_ptr_we, cur_req, "ptr_we", 128'(ptr_we), 128'(e_ptr_we));
    if (e_ptr_we)
      chk(ptr_data == e_ptr_data && ptr_sel == e_ptr_sel && ptr_page == e_ptr_page,
          cur_req, "ptr", {ptr_data[123:0], ptr_sel, ptr_page}, {e_ptr_data[123:0], e_ptr_sel, e_ptr_page});
    chk(dw_we == e_dw_we, cur_req, "dw_we", 128'(dw_we), 128'(e_dw_we));
    if (e_dw_we)
      chk(dw_data == e_dw_data && dw_sel == e_dw_sel && dw_page == e_dw_page,
          cur_req, "dw", {dw_data, dw_sel, dw_page}, {e_dw_data, e_dw_sel, e_dw_page});
  endtask

  // kind: 0 none, 1 wide, 2 sram, 3 pointer, 4 event queue, 5 timer
  task automatic classify(input logic [15:0] a, output int kind, output int ix,
                          output int dw, output int pg, output int tg, output bit sl);
    int o;
    pg = int'(a[15:13]);
    o  = int'(a[12:0]);
    kind = 0; ix = 0; sl = 0;
    dw = (o / 4) % 4;
    tg = int'(a) - (int'(a) % 16);
    if (pg == 0 && o < NW * 16) begin
      kind = 1; ix = o / 16;
    end else if (pg == 0 && o >= 'h1000 && o < 'h1000 + NS * 8) begin
      kind = 2; ix = (o - 'h1000) / 8; dw = (o / 4) % 2; tg = int'(a) - (int'(a) % 8);
    end else if (pg < NP) begin
      if (o - (o % 16) == 'h830) kind = 3;
      else if (o - (o % 16) == 'hA10) begin kind = 3; sl = 1; end
      else if (o == 'h400) kind = 4;
      else if (o == 'h420) begin kind = 5; sl = 1; end
    end
  endtask

  task automatic model(input bit rd, input bit wr, input logic [15:0] a, input logic [31:0] d);
    int k, ix, dw, pg, tg;
    bit sl, hit;
    logic [3:0] bm, nm, full;
    logic [127:0] bd, nd, fill, live, src;
    classify(a, k, ix, dw, pg, tg, sl);
    e_rvalid = rd && !wr;
    e_ptr_we = 0;
    e_dw_we  = 0;
    if (wr) begin
      hit = (cmask != 0) && (ctag == tg);
      bm = hit ? cmask : 4'h0;
      bd = hit ? cdata : 128'h0;
      fill = 0;
      for (int i = 0; i < 4; i++) if (bm[i]) fill[i*32 +: 32] = bd[i*32 +: 32];
      nm = bm | (4'b0001 << dw);
      nd = fill;
      nd[dw*32 +: 32] = d;
      if (k == 1 || k == 2) begin
        full = (k == 2) ? 4'h3 : 4'hF;
        if (nm == full) begin
          if (k == 1) mw[ix] = nd; else ms[ix] = nd[63:0];
          cmask = 0; ctag = 0; cdata = 0;
        end else begin
          ctag = tg; cmask = nm; cdata = nd;
        end
      end else if (k == 3) begin
        if (dw == 3) begin
          e_ptr_we = 1; e_ptr_data = {d, fill[95:0]}; e_ptr_sel = sl; e_ptr_page = 3'(pg);
          if (hit) begin cmask = 0; ctag = 0; cdata = 0; end
        end else if (cmask == 0 || hit) begin
          ctag = tg; cmask = nm; cdata = nd;
        end
      end else if (k == 4 || k == 5) begin
        e_dw_we = 1; e_dw_sel = sl; e_dw_page = 3'(pg); e_dw_data = d;
        if (k == 5 && pg == 0) begin cmask = 0; ctag = 0; cdata = 0; end
      end
    end else if (rd) begin
      if (k == 1 || k == 2) begin
        live = (k == 1) ? mw[ix] : {64'h0, ms[ix]};
        if (dw == 0 || !lv || ltag != tg) begin
          lv = 1; ltag = tg; ldata = live; src = live;
        end else src = ldata;
        e_rdata = src[dw*32 +: 32];
      end else e_rdata = 0;
    end
  endtask

  task automatic step(input string req, input bit rd, input bit wr,
                      input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    compare();
    cur_req = req;
    hst_rd = rd; hst_wr = wr; hst_addr = a; hst_wdata = d;
    model(rd, wr, a, d);
  endtask

  task automatic wr32(input string req, input logic [15:0] a, input logic [31:0] d);
    step(req, 0, 1, a, d);
  endtask
  task automatic rd32(input string req, input logic [15:0] a);
    step(req, 1, 0, a, 32'h0);
  endtask
  task automatic idle(input string req);
    step(req, 0, 0, 16'h0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog expired act=0 exp=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NW; i++) mw[i] = 0;
    for (int i = 0; i < NS; i++) ms[i] = 0;
    ctag = 0; cmask = 0; cdata = 0; lv = 0; ltag = 0; ldata = 0;
    e_rvalid = 0; e_ptr_we = 0; e_dw_we = 0; e_rdata = 0; e_ptr_sel = 0; e_dw_sel = 0;
    e_ptr_page = 0; e_dw_page = 0; e_ptr_data = 0; e_dw_data = 0;
    hst_rd = 0; hst_wr = 0; hst_addr = 0; hst_wdata = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < 3; i++) idle("R1");
    rd32("R1", 16'h0000); rd32("R1", 16'h0004); rd32("R1", 16'h100C); idle("R1");

    // R4 shuffled order, R12 reads during collection
    wr32("R4", 16'h001C, 32'hD3D3D3D3);
    wr32("R4", 16'h0010, 32'hA0A0A0A0);
    wr32("R4", 16'h0018, 32'hC2C2C2C2);
    rd32("R12", 16'h0010); rd32("R12", 16'h0830); rd32("R12", 16'h0400);
    rd32("R12", 16'h2420); rd32("R12", 16'h0F00);
    wr32("R4", 16'h0014, 32'hB1B1B1B1);
    rd32("R4", 16'h0010); rd32("R4", 16'h0014); rd32("R4", 16'h0018); rd32("R4", 16'h001C);

    // R2 stale snapshot
    rd32("R2", 16'h0020);
    wr32("R2", 16'h0020, 32'h11111111); wr32("R2", 16'h0024, 32'h22222222);
    wr32("R2", 16'h0028, 32'h33333333); wr32("R2", 16'h002C, 32'h44444444);
    rd32("R2", 16'h0024); rd32("R2", 16'h0020); rd32("R2", 16'h0024);
    // R3 jump to another register's higher dword
    rd32("R3", 16'h0010); rd32("R3", 16'h0028); rd32("R3", 16'h001C);

    // R5 restart
    wr32("R5", 16'h0030, 32'h30303030); wr32("R5", 16'h0034, 32'h34343434);
    wr32("R5", 16'h0040, 32'h40404040); wr32("R5", 16'h0044, 32'h41414141);
    wr32("R5", 16'h0048, 32'h42424242); wr32("R5", 16'h004C, 32'h43434343);
    wr32("R5", 16'h0038, 32'h38383838); wr32("R5", 16'h003C, 32'h3C3C3C3C);
    rd32("R5", 16'h0030); rd32("R5", 16'h0040); rd32("R5", 16'h004C);
    wr32("R5", 16'h0030, 32'h50505050); wr32("R5", 16'h0034, 32'h54545454);
    rd32("R5", 16'h0030); rd32("R5", 16'h0038); rd32("R5", 16'h003C);

    // R6 SRAM
    wr32("R6", 16'h100C, 32'hFACEFACE); rd32("R6", 16'h1008);
    wr32("R6", 16'h1008, 32'hBEEFBEEF);
    rd32("R6", 16'h1008); rd32("R6", 16'h100C);
    wr32("R6", 16'h1008, 32'h01020304); wr32("R6", 16'h100C, 32'h05060708);
    rd32("R6", 16'h100C); rd32("R6", 16'h1008); rd32("R6", 16'h100C);
    wr32("R6", 16'h1078, 32'h77777777); wr32("R6", 16'h107C, 32'h88888888);
    rd32("R6", 16'h107C);

    // R7 pointer commit with and without collected low dwords
    wr32("R7", 16'h0830, 32'hAAAA0000); wr32("R7", 16'h0834, 32'hAAAA1111);
    wr32("R7", 16'h083C, 32'hAAAA3333); idle("R7");
    wr32("R7", 16'h4A1C, 32'h12345678); idle("R7");
    wr32("R7", 16'h2A10, 32'h0000CAFE); wr32("R7", 16'h0A1C, 32'h9999AAAA);
    wr32("R7", 16'h2A1C, 32'h5555AAAA); idle("R7");
    wr32("R7", 16'h0050, 32'h50505050); wr32("R7", 16'h083C, 32'h0BADF00D);
    wr32("R7", 16'h0054, 32'h51515151); wr32("R7", 16'h0058, 32'h52525252);
    wr32("R7", 16'h005C, 32'h53535353); rd32("R7", 16'h0050);

    // R8 conflict drop
    wr32("R8", 16'h0060, 32'h60606060); wr32("R8", 16'h0830, 32'hDEADDEAD);
    wr32("R8", 16'h0834, 32'hDEADBEEF); wr32("R8", 16'h083C, 32'h0C0C0C0C);
    wr32("R8", 16'h0064, 32'h61616161); wr32("R8", 16'h0068, 32'h62626262);
    wr32("R8", 16'h006C, 32'h63636363); rd32("R8", 16'h0060); rd32("R8", 16'h006C);

    // R9 pages
    wr32("R9", 16'h8830, 32'h1); wr32("R9", 16'h883C, 32'h2); wr32("R9", 16'h8400, 32'h3);
    wr32("R9", 16'hE420, 32'h4); wr32("R9", 16'h6400, 32'h5); wr32("R9", 16'h6A1C, 32'h6);
    wr32("R9", 16'h2010, 32'h7); idle("R9");

    // R10 / R11 paged dword registers and invalidation
    wr32("R10", 16'h2400, 32'hE0E0E0E0); wr32("R10", 16'h0420, 32'h7171);
    wr32("R11", 16'h0070, 32'h70707070); wr32("R11", 16'h2420, 32'h00000042);
    wr32("R11", 16'h0074, 32'h74747474); wr32("R11", 16'h0078, 32'h78787878);
    wr32("R11", 16'h007C, 32'h7C7C7C7C); rd32("R11", 16'h0070);
    wr32("R11", 16'h0000, 32'hF0F0F0F0); wr32("R11", 16'h0420, 32'h00000043);
    wr32("R11", 16'h0004, 32'hF1F1F1F1); wr32("R11", 16'h0008, 32'hF2F2F2F2);
    wr32("R11", 16'h000C, 32'hF3F3F3F3); rd32("R11", 16'h0000);

    // R13 read/write together
    step("R13", 1, 1, 16'h0020, 32'h99999999);
    rd32("R13", 16'h0020); idle("R13"); rd32("R13", 16'h0024); idle("R13");

    idle("R13"); idle("R13");
    finish_run();
  end
endmodule